// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block gathers interrupt causes from the sub-units around an Ethernet MAC into one read-only 32-bit status word. Several causes are latched as sticky flags. These are the low-power-idle transitions, the timestamp events, PCS auto-negotiation completion, PCS link changes and RGMII/SMII link changes. Each flag is cleared by a read strobe from the companion status register that owns the cause, never by accessing this word. The management-counter causes are level summaries: each follows the "any bit set" state of its counter interrupt vector, and one further bit ORs those three summaries together.

Software reads the word through a simple read port. A read that hits the configured address returns the status in the same cycle, and any other access returns zero. The block has no write path, so writes cannot change it. A single interrupt output is high while any defined status bit is high.

Top module: `mac_irq_status`

## Requirements
- R1: Bit 10 sets after a clock edge where `lpi_tx_evt_i` or `lpi_rx_evt_i` is high. It stays set until an edge where `lpi_rd_i` is high and neither event is high.
- R2: Bit 9 sets after an edge where any of `ts_target_i`, `ts_sec_ovf_i` or `ts_aux_trig_i` is high. It clears after an edge with `ts_rd_i` high and no timestamp event.
- R3: Bits 7, 6 and 5 are combinationally high while any bit of `mmc_csum_irq_i`, `mmc_tx_irq_i` or `mmc_rx_irq_i` respectively is set, and low when that vector is all zero.
- R4: Bit 4 is high exactly when at least one of bits 7, 6 and 5 is high.
- R5: Bit 2 sets after an edge with `an_done_i` high. It clears after an edge with `an_rd_i` high and `an_done_i` low.
- R6: Bit 1 sets after an edge where `pcs_link_i` differs from its value at the previous edge. The first edge after reset is never counted as a change. The bit clears after an edge with `an_rd_i` high and no change.
- R7: Bit 0 sets after an edge where `phy_link_i` differs from its value at the previous edge, with the same first-edge rule as R6. It clears after an edge with `phy_rd_i` high and no change.
- R8: Bits 31 to 11, bit 8 and bit 3 always read zero. After reset, every sticky bit reads zero.
- R9: When a set event and the matching clearing read occur at the same edge, the sticky bit is 1 after that edge.
- R10: `rd_data_o` equals the status word when `rd_en_i` is high and `rd_addr_i` equals `REG_ADDR`. It is zero otherwise.
- R11: `irq_o` is high exactly when any defined status bit (10, 9, 7, 6, 5, 4, 2, 1, 0) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lpi_tx_evt_i | input | 1 | Transmit low-power-idle entry/exit pulse |
| lpi_rx_evt_i | input | 1 | Receive low-power-idle entry/exit pulse |
| lpi_rd_i | input | 1 | Read strobe of the LPI control/status register |
| ts_target_i | input | 1 | System time reached target time |
| ts_sec_ovf_i | input | 1 | Seconds counter overflow |
| ts_aux_trig_i | input | 1 | Auxiliary snapshot trigger |
| ts_rd_i | input | 1 | Read strobe of the timestamp status register |
| mmc_csum_irq_i | input | CSUM_W | Receive checksum-offload counter interrupt bits |
| mmc_tx_irq_i | input | TX_W | Transmit counter interrupt bits |
| mmc_rx_irq_i | input | RX_W | Receive counter interrupt bits |
| an_done_i | input | 1 | PCS auto-negotiation complete pulse |
| pcs_link_i | input | 1 | PCS link status level |
| an_rd_i | input | 1 | Read strobe of the auto-negotiation status register |
| phy_link_i | input | 1 | RGMII/SMII link status level |
| phy_rd_i | input | 1 | Read strobe of the RGMII/SMII status register |
| rd_en_i | input | 1 | Register read enable |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | OR of all defined status bits |

## Verification
The main stimulus is a long sparse random run. Event pulses, clearing strobes, link toggles and counter vectors are all drawn independently, so collisions between sets and clears arise naturally. A behavioural model is compared on every cycle, bit by bit. This tells the sticky-hold, clear-on-read and level-follow behaviours apart, and it catches strobes wired to the wrong flag because only the owning read may clear each bit. Link inputs held high through reset separate a correct first-edge rule from a false change report. Reads to a wrong address or with the enable low show whether the read port gates its data. A directed collision of event and read at the same edge confirms that the set has priority.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned B_PHY_CHG  = 0;
  localparam int unsigned B_PCS_CHG  = 1;
  localparam int unsigned B_AN_DONE  = 2;
  localparam int unsigned B_MMC_ANY  = 4;
  localparam int unsigned B_MMC_RX   = 5;
  localparam int unsigned B_MMC_TX   = 6;
  localparam int unsigned B_MMC_CSUM = 7;
  localparam int unsigned B_TS       = 9;
  localparam int unsigned B_LPI      = 10;
  localparam logic [DATA_W-1:0] DEF_MASK = 32'h0000_06F7;
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set has priority over clear
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r1_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/irq_link_change.sv
module irq_link_change (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  output logic chg_o
);
  logic prev_q, primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= link_i;
      primed_q <= 1'b1;
    end
  end

  // first edge after reset only captures the level
  assign chg_o = primed_q && (link_i != prev_q);

  a_r6_toggle_detected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && (link_i != $past(link_i))) |-> chg_o);
  a_r7_steady_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && (link_i == $past(link_i))) |-> !chg_o);
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
  import mac_irq_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter logic [AW-1:0] REG_ADDR = 12'h038,
  parameter int unsigned CSUM_W   = 8,
  parameter int unsigned TX_W     = 8,
  parameter int unsigned RX_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lpi_tx_evt_i,
  input  logic              lpi_rx_evt_i,
  input  logic              lpi_rd_i,
  input  logic              ts_target_i,
  input  logic              ts_sec_ovf_i,
  input  logic              ts_aux_trig_i,
  input  logic              ts_rd_i,
  input  logic [CSUM_W-1:0] mmc_csum_irq_i,
  input  logic [TX_W-1:0]   mmc_tx_irq_i,
  input  logic [RX_W-1:0]   mmc_rx_irq_i,
  input  logic              an_done_i,
  input  logic              pcs_link_i,
  input  logic              an_rd_i,
  input  logic              phy_link_i,
  input  logic              phy_rd_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned N_STICKY = 5;
  localparam int unsigned S_LPI = 0, S_TS = 1, S_AN = 2, S_PCS = 3, S_PHY = 4;

  logic                pcs_chg, phy_chg;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic                lvl_csum, lvl_tx, lvl_rx;
  logic [DATA_W-1:0]   status;
  logic                hit;

  irq_link_change u_pcs_chg (.clk_i, .rst_ni, .link_i(pcs_link_i), .chg_o(pcs_chg));
  irq_link_change u_phy_chg (.clk_i, .rst_ni, .link_i(phy_link_i), .chg_o(phy_chg));

  always_comb begin
    st_set[S_LPI] = lpi_tx_evt_i | lpi_rx_evt_i;
    st_clr[S_LPI] = lpi_rd_i;
    st_set[S_TS]  = ts_target_i | ts_sec_ovf_i | ts_aux_trig_i;
    st_clr[S_TS]  = ts_rd_i;
    st_set[S_AN]  = an_done_i;
    st_clr[S_AN]  = an_rd_i;
    st_set[S_PCS] = pcs_chg;
    st_clr[S_PCS] = an_rd_i;   // shares the auto-negotiation status read
    st_set[S_PHY] = phy_chg;
    st_clr[S_PHY] = phy_rd_i;
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    irq_sticky_flag u_flag (
      .clk_i, .rst_ni,
      .set_i(st_set[g]),
      .clr_i(st_clr[g]),
      .q_o  (st_q[g])
    );
  end

  assign lvl_csum = |mmc_csum_irq_i;
  assign lvl_tx   = |mmc_tx_irq_i;
  assign lvl_rx   = |mmc_rx_irq_i;

  always_comb begin
    status             = '0;
    status[B_LPI]      = st_q[S_LPI];
    status[B_TS]       = st_q[S_TS];
    status[B_MMC_CSUM] = lvl_csum;
    status[B_MMC_TX]   = lvl_tx;
    status[B_MMC_RX]   = lvl_rx;
    status[B_MMC_ANY]  = lvl_csum | lvl_tx | lvl_rx;
    status[B_AN_DONE]  = st_q[S_AN];
    status[B_PCS_CHG]  = st_q[S_PCS];
    status[B_PHY_CHG]  = st_q[S_PHY];
  end

  assign hit       = rd_en_i && (rd_addr_i == REG_ADDR);
  assign rd_data_o = hit ? status : '0;
  assign irq_o     = |(status & DEF_MASK);

  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~DEF_MASK) == '0);
  a_r10_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rd_data_o == '0));
  a_r4_summary_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_MMC_ANY] == (|rd_data_o[B_MMC_CSUM:B_MMC_RX]));
  a_r11_irq_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (irq_o == (|rd_data_o)));
  a_r5_an_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_done_i |=> st_q[S_AN]);
endmodule

// File: tb/mac_irq_status_bench.sv
module mac_irq_status_bench;
  localparam int AW = 12;
  localparam logic [AW-1:0] RA = 12'h038;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic lpi_tx, lpi_rx, lpi_rd, ts_tg, ts_ov, ts_ax, ts_rd;
  logic [7:0] m_cs, m_tx, m_rx;
  logic an_dn, pcs_lk, an_rd, phy_lk, phy_rd, rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data;
  logic irq;

  mac_irq_status u_mac_irq_status (
    .clk_i(clk), .rst_ni(rst_n),
    .lpi_tx_evt_i(lpi_tx), .lpi_rx_evt_i(lpi_rx), .lpi_rd_i(lpi_rd),
    .ts_target_i(ts_tg), .ts_sec_ovf_i(ts_ov), .ts_aux_trig_i(ts_ax), .ts_rd_i(ts_rd),
    .mmc_csum_irq_i(m_cs), .mmc_tx_irq_i(m_tx), .mmc_rx_irq_i(m_rx),
    .an_done_i(an_dn), .pcs_link_i(pcs_lk), .an_rd_i(an_rd),
    .phy_link_i(phy_lk), .phy_rd_i(phy_rd),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit e_lpi, e_ts, e_an, e_pcs, e_phy, p_pcs, p_phy, primed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lpi = 0; e_ts = 0; e_an = 0; e_pcs = 0; e_phy = 0;
      p_pcs = 0; p_phy = 0; primed = 0;
    end else begin
      bit cp, cy;
      cp = primed && (pcs_lk != p_pcs);
      cy = primed && (phy_lk != p_phy);
      e_lpi = (lpi_tx || lpi_rx) ? 1'b1 : (lpi_rd ? 1'b0 : e_lpi);
      e_ts  = (ts_tg || ts_ov || ts_ax) ? 1'b1 : (ts_rd ? 1'b0 : e_ts);
      e_an  = an_dn ? 1'b1 : (an_rd ? 1'b0 : e_an);
      e_pcs = cp ? 1'b1 : (an_rd ? 1'b0 : e_pcs);
      e_phy = cy ? 1'b1 : (phy_rd ? 1'b0 : e_phy);
      p_pcs = pcs_lk; p_phy = phy_lk; primed = 1;
    end
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[10] = e_lpi; w[9] = e_ts;
    w[7] = |m_cs; w[6] = |m_tx; w[5] = |m_rx;
    w[4] = (|m_cs) | (|m_tx) | (|m_rx);
    w[2] = e_an; w[1] = e_pcs; w[0] = e_phy;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [31:0] e = exp_word();
    if (rd_en && rd_addr == RA) begin
      chk("R1 lpi bit10", 32'(rd_data[10]), 32'(e[10]));
      chk("R2 ts bit9", 32'(rd_data[9]), 32'(e[9]));
      chk("R3 mmc bits7:5", 32'(rd_data[7:5]), 32'(e[7:5]));
      chk("R4 mmc summary bit4", 32'(rd_data[4]), 32'(e[4]));
      chk("R5 an bit2", 32'(rd_data[2]), 32'(e[2]));
      chk("R6 pcs link bit1", 32'(rd_data[1]), 32'(e[1]));
      chk("R7 phy link bit0", 32'(rd_data[0]), 32'(e[0]));
      chk("R8 reserved", rd_data & 32'hFFFF_F908, 32'h0);
    end else begin
      chk("R10 miss reads zero", rd_data, 32'h0);
    end
    chk("R11 irq", 32'(irq), 32'(|e));
  endtask

  task automatic idle();
    lpi_tx = 0; lpi_rx = 0; lpi_rd = 0; ts_tg = 0; ts_ov = 0; ts_ax = 0; ts_rd = 0;
    m_cs = 0; m_tx = 0; m_rx = 0; an_dn = 0; an_rd = 0; phy_rd = 0;
    rd_en = 1; rd_addr = RA;
  endtask

  function automatic logic rp(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic main_seq();
    idle();
    pcs_lk = 1; phy_lk = 1;  // high through reset: first edge must not flag
    repeat (3) @(negedge clk);
    #1 chk("R8 reset state", rd_data, 32'h0);
    rst_n = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1 check_all();
    end
    chk("R6 no change after reset", 32'(rd_data[1:0]), 32'h0);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lpi_tx = rp(4); lpi_rx = rp(4); lpi_rd = rp(10);
      ts_tg = rp(3); ts_ov = rp(2); ts_ax = rp(2); ts_rd = rp(10);
      m_cs = rp(30) ? 8'(1 << ($urandom % 8)) : 8'h0;
      m_tx = rp(30) ? 8'($urandom) : 8'h0;
      m_rx = rp(30) ? 8'(1 << ($urandom % 8)) : 8'h0;
      an_dn = rp(4); an_rd = rp(10); phy_rd = rp(10);
      if (rp(5)) pcs_lk = ~pcs_lk;
      if (rp(5)) phy_lk = ~phy_lk;
      rd_en = rp(85);
      rd_addr = rp(90) ? RA : AW'($urandom);
      #1 check_all();
    end
    // R9 directed: event and clearing read collide on one edge
    @(negedge clk); idle(); lpi_rd = 1; an_rd = 1; phy_rd = 1;
    @(negedge clk); idle(); lpi_tx = 1;
    @(negedge clk); lpi_rd = 1;
    an_dn = 1; an_rd = 1; phy_lk = ~phy_lk; phy_rd = 1;
    @(negedge clk); idle(); #1;
    chk("R9 lpi set wins", 32'(rd_data[10]), 32'h1);
    chk("R9 an set wins", 32'(rd_data[2]), 32'h1);
    chk("R9 phy set wins", 32'(rd_data[0]), 32'h1);
    check_all();
    @(negedge clk); lpi_rd = 1; an_rd = 1; phy_rd = 1;
    @(negedge clk); idle(); #1;
    chk("R1 cleared by read", 32'(rd_data[10]), 32'h0);
    chk("R5 cleared by read", 32'(rd_data[2]), 32'h0);
    chk("R7 cleared by read", 32'(rd_data[0]), 32'h0);
    check_all();
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule